// File: doc/BRIEF.md
# Four-Channel Double-Buffered PWM Generator

This block drives four PWM outputs from one shared 12-bit time base. Software programs a period value, picks one of four counting modes and writes a 13-bit duty value for each channel. Each duty write lands in a staging (buffer) register. The compare against the timer always uses a separate active register. The block copies all four buffers into the active registers at once, and only at a timer boundary that depends on the mode. An output therefore never shows half of an old setting and half of a new one.

Two modes are edge-aligned: free-running and single-shot. In these modes the timer ramps from 0 to the period value, and a channel is high from the start of the ramp until the timer reaches its duty value. The other two modes are centre-aligned: the timer climbs to the period value and falls back to 0. One of them reloads the duties once per cycle, at the bottom of the ramp. The other reloads them at both the bottom and the top. While the time base is stopped, the active registers track the buffers on every clock. The values written before start-up therefore apply from the very first period.

Top module: `pwm4_dbuf`

## Requirements
- R1: After reset, all four outputs are low, the timer reads 0, the run flag and direction flag are 0 and the update pulse is 0.
- R2: A write is captured on the clock edge where `wr_en` is high, and it is visible from the next cycle. Address 0 sets the period from `wr_data[11:0]`. Address 1 is the control register: bits [1:0] select the mode (0 free-running, 1 single-shot, 2 up/down, 3 up/down with double update) and bit 2 is the run enable. Addresses 4 to 7 set the duty buffers of channels 0 to 3 from `wr_data[12:0]`.
- R3: While stopped, all outputs are low and the timer is held at 0. The active duty registers copy the buffers on every clock, so the first period after start-up uses the most recently written duties.
- R4: In free-running mode with period P, the timer reads 0 in the first cycle after the enable is written. It then steps by one each cycle up to P and returns to 0, so one period lasts P+1 cycles.
- R5: In the edge-aligned modes, a channel is high while the timer is below its active duty value. It is therefore high from timer 0 and goes low in the cycle where the timer equals the duty value.
- R6: An active duty of 0 keeps a channel low for the whole period. An active duty greater than P keeps it high for the whole period.
- R7: In the edge-aligned modes, the buffers move to the active registers on the edge where the timer leaves P for 0. A duty written in the middle of a period does not change the output until the next period.
- R8: In single-shot mode, the timer counts 0 to P once. On the edge leaving P, the run enable clears by itself and the timer stays at 0.
- R9: In both up/down modes, the timer counts 0, 1 … P, P−1 … 1, 0 and repeats every 2P cycles. The direction flag is 1 from the cycle after the peak up to and including the cycle at 0. A channel is high while its active duty exceeds the timer.
- R10: In up/down mode, the transfer happens only on edges that leave timer value 0.
- R11: In up/down mode with double update, the transfer happens on edges that leave timer value 0 and on edges that leave timer value P.
- R12: The update pulse is high for exactly the one cycle that follows each transfer event. This is the first cycle in which the new duties drive the outputs. The pulse stays low while the time base is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 13 | Register write data |
| pwm_out | output | 4 | PWM outputs, bit i is channel i |
| tmr_count | output | 12 | Current timer value |
| tmr_down | output | 1 | Timer is in the falling half (up/down modes) |
| tmr_run | output | 1 | Time base running |
| upd_pulse | output | 1 | One-cycle flag following a buffer-to-active transfer |

## Verification
If the enable is captured on edge E, the timer reads 0 and the outputs use the preloaded duties in the cycle after E. A transfer triggered by the timer value in cycle t shows in the outputs and in the update pulse in cycle t+1. The self-clear in single-shot mode and the zero timer after a stop show up one edge after their cause. The bench counts clock edges, logs each expected output against the exact edge number computed from these offsets, and compares in the low phase of the clock. Mid-period duty writes are timed so that they land strictly between two transfer edges, which makes the cycle in which they first take effect unambiguous.

// File: rtl/pwm4_dbuf.sv
module pwm4_dbuf #(
  parameter int CH = 4,
  parameter int TW = 12,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW:0]   wr_data,
  output logic [CH-1:0] pwm_out,
  output logic [TW-1:0] tmr_count,
  output logic          tmr_down,
  output logic          tmr_run,
  output logic          upd_pulse
);
  localparam int DW        = TW + 1;
  localparam int DUTY_BASE = 1 << (AW - 1);
  localparam logic [AW-1:0] A_PER = AW'(0);
  localparam logic [AW-1:0] A_CTL = AW'(1);

  logic [TW-1:0]         period_q, cnt_q;
  logic [1:0]            mode_q;
  logic                  run_q, down_q;
  logic [CH-1:0][DW-1:0] duty_buf, duty_act;
  logic                  xfer;

  wire at_top   = (cnt_q == period_q);
  wire at_zero  = (cnt_q == '0);
  wire ctl_wr   = wr_en && (wr_addr == A_CTL);
  wire xfer_evt = run_q && xfer;

  always_comb
    case (mode_q)
      2'd0, 2'd1: xfer = at_top;
      2'd2:       xfer = at_zero;
      default:    xfer = at_zero || at_top;
    endcase

  always_ff @(posedge clk)
    if (!rst_n)                           period_q <= '0;
    else if (wr_en && wr_addr == A_PER)   period_q <= wr_data[TW-1:0];

  always_ff @(posedge clk)
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 2'd0;
    end else if (ctl_wr) begin
      run_q  <= wr_data[2];
      mode_q <= wr_data[1:0];
    end else if (run_q && mode_q == 2'd1 && at_top) begin
      run_q  <= 1'b0;
    end

  always_ff @(posedge clk)
    if (!rst_n || !run_q) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (!mode_q[1]) begin
      cnt_q <= at_top ? '0 : cnt_q + 1'b1;
    end else if (!down_q) begin
      if (!at_top)       cnt_q <= cnt_q + 1'b1;
      else if (!at_zero) begin
        down_q <= 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end
    end else if (at_zero) begin
      down_q <= 1'b0;
      cnt_q  <= at_top ? '0 : TW'(1);
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    always_ff @(posedge clk)
      if (!rst_n) begin
        duty_buf[i] <= '0;
        duty_act[i] <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(DUTY_BASE + i)) duty_buf[i] <= wr_data;
        if (!run_q || xfer_evt)                     duty_act[i] <= duty_buf[i];
      end
    assign pwm_out[i] = run_q && (duty_act[i] > {1'b0, cnt_q});
  end

  always_ff @(posedge clk)
    if (!rst_n) upd_pulse <= 1'b0;
    else        upd_pulse <= xfer_evt;

  assign tmr_count = cnt_q;
  assign tmr_down  = down_q;
  assign tmr_run   = run_q;
endmodule

module pwm4_dbuf_chk #(
  parameter int CH = 4,
  parameter int TW = 12,
  parameter int AW = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [AW-1:0]         wr_addr,
  input logic [TW-1:0]         period_q,
  input logic [TW-1:0]         cnt_q,
  input logic [1:0]            mode_q,
  input logic                  run_q,
  input logic                  down_q,
  input logic [CH-1:0][TW:0]   duty_buf,
  input logic [CH-1:0][TW:0]   duty_act,
  input logic [CH-1:0]         pwm_out,
  input logic                  upd_pulse
);
  wire cw = wr_en && (wr_addr == AW'(1));

  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> pwm_out == '0);

  a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> duty_act == $past(duty_buf));

  a_r4_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && mode_q == 2'd0 && cnt_q == period_q && !cw |=> run_q && cnt_q == '0);

  a_r4_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && mode_q == 2'd0 && cnt_q != period_q && !cw |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r8_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && mode_q == 2'd1 && cnt_q == period_q && !cw |=> !run_q && cnt_q == '0);

  a_r9_turn: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && mode_q[1] && !down_q && cnt_q == period_q && cnt_q != '0 && !cw |=> down_q);

  a_r10_zero_only: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse && $past(mode_q) == 2'd2 |-> $past(cnt_q) == '0);

  a_r11_both_ends: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse && $past(mode_q) == 2'd3 |-> $past(cnt_q) == '0 || $past(cnt_q) == $past(period_q));

  a_r12_act_moves_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q) && !upd_pulse |-> $stable(duty_act));

  for (genvar i = 0; i < CH; i++) begin : g_chk
    a_r6_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && duty_act[i] == '0 |-> !pwm_out[i]);
    a_r6_full_on: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && cnt_q <= period_q && duty_act[i] > {1'b0, period_q} |-> pwm_out[i]);
  end
endmodule

bind pwm4_dbuf pwm4_dbuf_chk #(.CH(CH), .TW(TW), .AW(AW)) u_chk (.*);

// File: tb/tb_pwm4_dbuf.sv
module tb_pwm4_dbuf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic [3:0]  pwm_out;
  logic [11:0] tmr_count;
  logic        tmr_down, tmr_run, upd_pulse;

  pwm4_dbuf dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .tmr_count(tmr_count), .tmr_down(tmr_down),
    .tmr_run(tmr_run), .upd_pulse(upd_pulse)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    cyc;
    int    kind;
    int    val;
    string req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void expect_at(int c, int k, int v, string r);
    item_t it;
    it.cyc = c; it.kind = k; it.val = v; it.req = r;
    q.push_back(it);
  endfunction

  function automatic int sample(int k);
    case (k)
      0: return int'(pwm_out);
      1: return int'(tmr_count);
      2: return int'(tmr_down);
      3: return int'(tmr_run);
      default: return int'(upd_pulse);
    endcase
  endfunction

  always @(negedge clk) begin
    item_t it;
    int    act;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it  = q.pop_front();
      act = sample(it.kind);
      checks++;
      if (it.cyc != cyc || act != it.val) begin
        errors++;
        $display("FAIL %s kind %0d cycle %0d: actual %0d expected %0d", it.req, it.kind, it.cyc, act, it.val);
      end
    end
  end

  function automatic int pexp(int c, int a, int b, int d, int e);
    return {28'd0, e > c, d > c, b > c, a > c};
  endfunction

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 13'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic load(input int p, input int a, input int b, input int d, input int e);
    wr(0, p); wr(4, a); wr(5, b); wr(6, d); wr(7, e);
  endtask

  task automatic stop_tb();
    int d;
    d = cyc + 1;
    expect_at(d, 3, 0, "R3");
    expect_at(d, 0, 0, "R3");
    expect_at(d + 1, 1, 0, "R3");
    expect_at(d + 1, 4, 0, "R12");
    wr(1, 0);
    wait_to(d + 2);
  endtask

  initial begin
    int e, c, m, d1, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    c = cyc + 1;
    expect_at(c, 0, 0, "R1"); expect_at(c, 1, 0, "R1"); expect_at(c, 2, 0, "R1");
    expect_at(c, 3, 0, "R1"); expect_at(c, 4, 0, "R1");
    wait_to(c + 1);

    // free-running, P=7, duties 0/3/7/9, ch1 rewritten to 5 mid-period (R3 R4 R5 R6 R7 R12)
    load(7, 0, 3, 7, 9);
    e = cyc + 1;
    for (int k = 0; k < 18; k++) begin
      c  = k % 8;
      d1 = (k >= 8) ? 5 : 3;
      expect_at(e + k, 0, pexp(c, 0, d1, 7, 9), (k >= 8) ? "R7" : "R5 R6 R3");
      expect_at(e + k, 1, c, "R4");
      expect_at(e + k, 3, 1, "R4");
      expect_at(e + k, 4, (k > 0 && c == 0) ? 1 : 0, "R12");
    end
    wr(1, 3'b100);
    wait_to(e + 2);
    wr(5, 5);
    wait_to(e + 18);
    stop_tb();

    // single-shot, P=4 (R8)
    load(4, 1, 2, 4, 5);
    e = cyc + 1;
    for (int k = 0; k < 8; k++) begin
      c = (k <= 4) ? k : 0;
      expect_at(e + k, 0, (k <= 4) ? pexp(c, 1, 2, 4, 5) : 0, "R8");
      expect_at(e + k, 1, c, "R8");
      expect_at(e + k, 3, (k <= 4) ? 1 : 0, "R8");
      expect_at(e + k, 4, (k == 5) ? 1 : 0, "R12");
    end
    wr(1, 3'b101);
    wait_to(e + 8);
    stop_tb();

    // up/down, P=5, ch2 rewritten on the falling slope (R9 R10)
    load(5, 0, 2, 5, 6);
    e = cyc + 1;
    for (int k = 0; k < 22; k++) begin
      m  = k % 10;
      c  = (m <= 5) ? m : 10 - m;
      d2 = (k >= 11) ? 1 : 5;
      expect_at(e + k, 0, pexp(c, 0, 2, d2, 6), (k >= 11) ? "R10" : "R9 R6");
      expect_at(e + k, 1, c, "R9");
      expect_at(e + k, 2, (m > 5 || (m == 0 && k > 0)) ? 1 : 0, "R9");
      expect_at(e + k, 4, (k >= 1 && (k - 1) % 10 == 0) ? 1 : 0, "R10");
    end
    wr(1, 3'b110);
    wait_to(e + 6);
    wr(6, 1);
    wait_to(e + 22);
    stop_tb();

    // up/down with double update, P=5, ch1 rewritten on the rising slope (R11)
    load(5, 3, 3, 3, 3);
    e = cyc + 1;
    for (int k = 0; k < 22; k++) begin
      m  = k % 10;
      c  = (m <= 5) ? m : 10 - m;
      d1 = (k >= 6) ? 0 : 3;
      expect_at(e + k, 0, pexp(c, 3, d1, 3, 3), "R11");
      expect_at(e + k, 1, c, "R9");
      expect_at(e + k, 4, (k >= 1 && (k - 1) % 5 == 0) ? 1 : 0, "R11");
    end
    wr(1, 3'b111);
    wait_to(e + 1);
    wr(5, 0);
    wait_to(e + 22);
    stop_tb();

    @(negedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 unconsumed items: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule